// File: doc/BRIEF.md
# Dual-Channel Serial DAC Driver

This block feeds a two-channel 12-bit digital-to-analog converter module over four wires: one active-low frame strobe, one serial clock, and one serial data line per channel. The host presents two unsigned 12-bit codes and raises a start request. On the rising edge of that request the block takes a copy of both codes. It then sends both codes at the same time, one on each data line. A code of 0 gives zero volts and 4095 gives full scale.

Each frame carries 16 serial bits. The first four bits are zeros, which select the converter's normal operating mode. The 12 code bits follow, most significant bit first. The serial clock runs at half the system clock, so one frame takes 32 system clocks. The block is meant for system clocks of up to 60 MHz, usually 40 or 50 MHz. New data appears on each rising serial-clock edge, which leaves the falling edge for the converter to sample it. A busy flag covers the whole frame, and a one-clock done pulse marks its end.

Top module: `dual_dac_serializer`

## Requirements
- R1: After reset, frame_n is 1, sclk is 0, both data lines are 0, busy is 0 and done is 0.
- R2: A 0-to-1 change of start_req seen while idle captures code_a and code_b together; changing the codes after the capture cycle does not alter the frame in progress.
- R3: frame_n goes low on the clock edge that captures the codes and stays low for exactly 32 system clocks.
- R4: During a frame, sclk is 1 in the first frame cycle and toggles on every system clock, giving 16 rising edges; sclk is 0 whenever frame_n is 1.
- R5: Each data line carries 16 bits, each held for two system clocks and changing only together with a rising sclk: bits 15..12 are 0, then code bits 11 down to 0.
- R6: code_a appears on sdata_a and code_b on sdata_b, aligned bit for bit.
- R7: Holding start_req at 1 after a frame starts produces exactly one frame.
- R8: A rising edge of start_req during a frame is ignored: the frame keeps its length and data, and no new frame follows it.
- R9: busy is 1 from the capture edge until the edge that returns frame_n to 1, and then returns to 0, so busy always equals the inverse of frame_n.
- R10: done is a single-clock pulse in the cycle in which frame_n returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start request; its rising edge begins a frame |
| code_a | input | 12 | Unsigned code for channel A |
| code_b | input | 12 | Unsigned code for channel B |
| frame_n | output | 1 | Active-low frame strobe |
| sclk | output | 1 | Serial clock, half the system clock rate during a frame |
| sdata_a | output | 1 | Serial data for channel A |
| sdata_b | output | 1 | Serial data for channel B |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-clock pulse at the end of a frame |

## Verification
The tests use four code pairs. Zero with 4095 sets one line to all ones and the other to all zeros, so a swapped channel shows up at once. The pair 0x800 and 0x001 uses single set bits at opposite ends, so a reversed bit order or an off-by-one shift is exposed. A mixed pair such as 0xA5C and 0x3A1 catches a bit that is dropped or stuck. One further frame changes the codes, drops start_req and raises it again while the frame is running; it shows whether the block captured the codes and whether it wrongly reacts to edges during a frame. A run that holds start_req high shows the difference between edge triggering and level triggering.

// File: rtl/dac_drv_pkg.sv
package dac_drv_pkg;
  // Per-cycle control issued by the frame timer to every lane shifter
  typedef struct packed {
    logic load;   // capture a fresh code
    logic shift;  // advance to the next serial bit
    logic clear;  // frame finished, park the line low
  } lane_ctrl_t;
endpackage

// File: rtl/go_rise_detect.sv
module go_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_in;
  end

  assign rise = level_in & ~level_q;
endmodule

// File: rtl/frame_timer.sv
module frame_timer
  import dac_drv_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output lane_ctrl_t ctl,
  output logic       sclk,
  output logic       frame_n,
  output logic       busy,
  output logic       done
);
  localparam int STEPS  = 2 * FRAME_BITS;
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  logic [STEP_W-1:0] step;
  logic              odd_step;
  logic              last_step;

  assign odd_step  = step[0];
  assign last_step = (step == LAST);

  always_comb begin
    ctl.load  = start & ~busy;
    ctl.shift = busy & odd_step & ~last_step;
    ctl.clear = busy & last_step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step    <= '0;
      sclk    <= 1'b0;
      frame_n <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          frame_n <= 1'b0;
          sclk    <= 1'b1;
          step    <= '0;
        end
      end else if (!odd_step) begin
        sclk <= 1'b0;
        step <= step + STEP_W'(1);
      end else if (last_step) begin
        busy    <= 1'b0;
        frame_n <= 1'b1;
        done    <= 1'b1;
        sclk    <= 1'b0;
        step    <= '0;
      end else begin
        sclk <= 1'b1;
        step <= step + STEP_W'(1);
      end
    end
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
  import dac_drv_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int PAD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  lane_ctrl_t        ctl,
  input  logic [CODE_W-1:0] code,
  output logic              sdata
);
  localparam int WORD_W = CODE_W + PAD_W;

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) word_q <= '0;
    else if (ctl.load)    word_q <= {{PAD_W{1'b0}}, code};
    else if (ctl.shift)   word_q <= {word_q[WORD_W-2:0], 1'b0};
  end

  assign sdata = word_q[WORD_W-1];
endmodule

// File: rtl/dual_dac_serializer.sv
module dual_dac_serializer
  import dac_drv_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int PAD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output logic              frame_n,
  output logic              sclk,
  output logic              sdata_a,
  output logic              sdata_b,
  output logic              busy,
  output logic              done
);
  localparam int NUM_CH     = 2;
  localparam int FRAME_BITS = CODE_W + PAD_W;

  logic              start_rise;
  lane_ctrl_t        ctl;
  logic [CODE_W-1:0] codes [NUM_CH];
  logic              lanes [NUM_CH];

  assign codes[0] = code_a;
  assign codes[1] = code_b;
  assign sdata_a  = lanes[0];
  assign sdata_b  = lanes[1];

  go_rise_detect u_edge (
    .clk      (clk),
    .rst      (rst),
    .level_in (start_req),
    .rise     (start_rise)
  );

  frame_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (start_rise),
    .ctl     (ctl),
    .sclk    (sclk),
    .frame_n (frame_n),
    .busy    (busy),
    .done    (done)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    lane_shifter #(.CODE_W(CODE_W), .PAD_W(PAD_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .ctl   (ctl),
      .code  (codes[g]),
      .sdata (lanes[g])
    );
  end
endmodule

// File: rtl/dual_dac_serializer_chk.sv
module dual_dac_serializer_chk #(
  parameter int FRAME_CLKS = 32
) (
  input logic clk,
  input logic rst,
  input logic frame_n,
  input logic sclk,
  input logic sdata_a,
  input logic sdata_b,
  input logic busy,
  input logic done
);
  localparam int CNT_W = $clog2(FRAME_CLKS + 2);
  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || frame_n) low_cnt <= '0;
    else                low_cnt <= low_cnt + CNT_W'(1);
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (frame_n && !sclk && !sdata_a && !sdata_b && !busy && !done));

  assert_busy_window_R9: assert property (@(posedge clk) disable iff (rst)
    busy == !frame_n);

  assert_done_edge_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (frame_n && !busy && $past(!frame_n)));

  assert_done_needed_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_n) |-> done);

  assert_sclk_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    (!frame_n && $past(!frame_n)) |-> (sclk != $past(sclk)));

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (rst)
    frame_n |-> !sclk);

  assert_data_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
    (!frame_n && $past(!frame_n) && !$rose(sclk)) |-> ($stable(sdata_a) && $stable(sdata_b)));

  assert_frame_len_R3: assert property (@(posedge clk) disable iff (rst)
    (!frame_n) |-> (low_cnt < CNT_W'(FRAME_CLKS)));

  assert_frame_end_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_n && $past(!frame_n)) |-> ($past(low_cnt) == CNT_W'(FRAME_CLKS - 1)));
endmodule

bind dual_dac_serializer dual_dac_serializer_chk #(.FRAME_CLKS(2 * (CODE_W + PAD_W))) u_chk (
  .clk     (clk),
  .rst     (rst),
  .frame_n (frame_n),
  .sclk    (sclk),
  .sdata_a (sdata_a),
  .sdata_b (sdata_b),
  .busy    (busy),
  .done    (done)
);

// File: tb/dual_dac_serializer_test.sv
module dual_dac_serializer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_req = 1'b0;
  logic [11:0] code_a = '0;
  logic [11:0] code_b = '0;
  logic        frame_n, sclk, sdata_a, sdata_b, busy, done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dual_dac_serializer uut (
    .clk(clk), .rst(rst), .start_req(start_req),
    .code_a(code_a), .code_b(code_b),
    .frame_n(frame_n), .sclk(sclk), .sdata_a(sdata_a), .sdata_b(sdata_b),
    .busy(busy), .done(done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      report();
    end
  end

  task automatic t_reset;
    @(negedge clk);
    check("R1 frame_n", frame_n, 1);
    check("R1 sclk", sclk, 0);
    check("R1 sdata_a", sdata_a, 0);
    check("R1 sdata_b", sdata_b, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
  endtask

  // mode 0: normal, start_req dropped after first cycle
  // mode 1: start_req held high for the whole frame and after it
  // mode 2: codes changed and start_req re-raised mid-frame
  task automatic t_frame(input logic [11:0] a, input logic [11:0] b, input int mode);
    logic [15:0] wa, wb;
    wa = {4'b0000, a};
    wb = {4'b0000, b};
    code_a = a;
    code_b = b;
    start_req = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      check("R3 frame_n low", frame_n, 0);
      check("R9 busy", busy, 1);
      check("R10 done quiet", done, 0);
      check("R4 sclk phase", sclk, (k % 2 == 0));
      check("R5 R6 sdata_a", sdata_a, wa[15 - k/2]);
      check("R5 R6 sdata_b", sdata_b, wb[15 - k/2]);
      if (mode == 0 && k == 0) start_req = 1'b0;
      if (mode == 2) begin
        if (k == 0) start_req = 1'b0;
        if (k == 3) begin code_a = ~a; code_b = ~b; end  // R2 capture
        if (k == 6) start_req = 1'b1;                    // R8 ignored edge
      end
    end
    @(negedge clk);
    check("R3 frame_n end", frame_n, 1);
    check("R9 busy end", busy, 0);
    check("R10 done pulse", done, 1);
    check("R4 sclk idle", sclk, 0);
    @(negedge clk);
    check("R10 done single", done, 0);
    if (mode != 0) begin
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (mode == 1) check("R7 no repeat", frame_n, 1);
        else           check("R8 no new frame", frame_n, 1);
      end
      start_req = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_frame(12'h000, 12'hFFF, 0);
    t_frame(12'h800, 12'h001, 0);
    t_frame(12'hA5C, 12'h3A1, 0);
    t_frame(12'hFFF, 12'h000, 1);
    t_frame(12'h5A3, 12'hC3C, 2);
    t_frame(12'h123, 12'hFED, 0);
    report();
  end
endmodule